// File: doc/BRIEF.md
# Glitch-Free System Clock Switcher

This block moves the system clock between three free-running sources: a primary oscillator, a slow secondary oscillator and an internal oscillator. A two-bit select input names the wanted source. Each source has a gating lane. The lane synchronises its own enable into its own clock domain and opens or closes its gate only on that clock's falling edge. As a result the merged output never carries a shortened high or low phase.

On a registered change of select, the lane of the old source closes its gate after two of its own rising edges. The lane of the new source sees every other gate closed and passes that fact through a three-stage synchroniser. It opens on the falling edge after that, so three to four new-source cycles pass before the first released edge. Each source has a stability input, and a lane never opens while its input is low, so a switch to an unready source simply waits. A separate output carries the primary clock at all times for a consumer that must not follow the switch.

Top module: `sysclk_switch`

## Requirements
- R1: Select 2'b00 picks the primary source, 2'b01 the secondary and 2'b10 or 2'b11 the internal source; once a switch completes, `clk_sys` toggles with the period of the picked source.
- R2: While `rst_n` is low, `clk_sys` is low and `busy` is high. After reset is released with the primary source stable, `clk_sys` runs from the primary source.
- R3: Every high phase of `clk_sys` lasts exactly half a period of one source, and at most one gate is open at any time.
- R4: The select is registered on a rising edge of `clk_sys`. After that edge, the old source gives exactly two more rising edges on `clk_sys` before the output stops low.
- R5: When the new source is already stable, it makes three or four rising edges between the stop of the old output and the first released edge of `clk_sys`.
- R6: While the new source's stability input is low, the switch waits: `clk_sys` stays low and `busy` stays high until the input rises.
- R7: `busy` rises when a changed select is registered. It falls on the new source's falling edge, half a new period before the first released rising edge, and then stays low.
- R8: A select change that arrives while `busy` is high does not disturb the running switch. It is taken on the first released edge and then performs its own switch.
- R9: `clk_aon` always carries the primary clock, whichever source drives `clk_sys`.
- R10: A select change between two codes of the same source (2'b10 and 2'b11) starts no switch: `busy` stays low and the clock keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator |
| clk_sec | input | 1 | Secondary low-frequency oscillator |
| clk_int | input | 1 | Internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Source select (00 primary, 01 secondary, 1x internal) |
| pri_ok | input | 1 | Primary source stable |
| sec_ok | input | 1 | Secondary source stable |
| int_ok | input | 1 | Internal source stable |
| clk_sys | output | 1 | Switched, glitch-free system clock |
| clk_aon | output | 1 | Always-on copy of the primary clock |
| busy | output | 1 | High while a switch is in progress |

## Verification
The bench counts source edges around every switch. A design that let the old gate close too early or too late would show an old-side count other than two. A new side with a short synchroniser would show fewer than three new edges in the pause. A design that re-registered the select while busy would abort the running switch, so a back-to-back pair of changes is issued. A switch to an unready source tests that the gate holds low rather than releasing a clock, and a change between the two internal codes tests that no spurious pause occurs. Every high phase on the output is timed to catch runt pulses at the seams.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  localparam int SRC_N = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  // high select bit wins; low bit only separates primary from secondary
  function automatic src_e sel_decode(input logic [1:0] s);
    if (s[1])      return SRC_INT;
    else if (s[0]) return SRC_SEC;
    else           return SRC_PRI;
  endfunction

  function automatic logic [SRC_N-1:0] src_onehot(input src_e s);
    logic [SRC_N-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  // a running gate follows the short tap; a closed gate needs both taps
  function automatic logic gate_next(input logic cur, input logic tap_off,
                                     input logic tap_on);
    return cur ? tap_off : (tap_on & tap_off);
  endfunction

endpackage

// File: rtl/clksw_lane.sv
module clksw_lane #(
  parameter int N_SYNC = 3
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic pick,
  input  logic src_ok,
  input  logic peers_idle,
  output logic en_q,
  output logic gclk
);
  import clksw_pkg::*;

  localparam int OFF_TAP = 1;
  localparam int ON_TAP  = N_SYNC - 1;

  logic              want;
  logic [N_SYNC-1:0] sync_q;

  assign want = pick & src_ok & peers_idle;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[N_SYNC-2:0], want};
  end

  // falling-edge update keeps the gated clock low when the gate moves
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= gate_next(en_q, sync_q[OFF_TAP], sync_q[ON_TAP]);
  end

  assign gclk = clk_src & en_q;

  // R3
  en_rise_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(en_q) |-> peers_idle);

  // R4
  en_drop_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
    (en_q && !sync_q[0] && !sync_q[OFF_TAP]) |=> !en_q);

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl (
  input  logic              clk_sys,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              busy,
  output clksw_pkg::src_e   tgt
);
  import clksw_pkg::*;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)     tgt <= SRC_PRI;
    else if (!busy) tgt <= sel_decode(sel);
  end

  // R8
  tgt_hold_chk: assert property (@(posedge clk_sys) disable iff (!rst_n)
    busy |=> $stable(tgt));

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch #(
  parameter int SYNC_STAGES = 3
) (
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       pri_ok,
  input  logic       sec_ok,
  input  logic       int_ok,
  output logic       clk_sys,
  output logic       clk_aon,
  output logic       busy
);
  import clksw_pkg::*;

  logic [SRC_N-1:0] clk_vec, ok_vec, en_vec, gclk_vec, pick_vec;
  src_e             tgt;

  assign clk_vec  = {clk_int, clk_sec, clk_pri};
  assign ok_vec   = {int_ok, sec_ok, pri_ok};
  assign pick_vec = src_onehot(tgt);

  clksw_ctrl u_ctrl (
    .clk_sys (clk_sys),
    .rst_n   (rst_n),
    .sel     (sel),
    .busy    (busy),
    .tgt     (tgt)
  );

  for (genvar i = 0; i < SRC_N; i++) begin : g_lane
    logic [SRC_N-1:0] others;
    assign others = en_vec & ~(SRC_N'(1) << i);
    clksw_lane #(.N_SYNC(SYNC_STAGES)) u_lane (
      .clk_src    (clk_vec[i]),
      .rst_n      (rst_n),
      .pick       (pick_vec[i]),
      .src_ok     (ok_vec[i]),
      .peers_idle (~|others),
      .en_q       (en_vec[i]),
      .gclk       (gclk_vec[i])
    );
  end

  assign clk_sys = |gclk_vec;
  assign clk_aon = clk_pri;
  assign busy    = (en_vec != pick_vec);

  // R3
  always_comb begin
    single_src_chk: assert ($onehot0(en_vec));
  end

endmodule

// File: tb/sim_sysclk_switch.sv
`timescale 1ps/1ps
module sim_sysclk_switch;

  typedef struct {
    int src;
    bit chk_new;
  } item_t;

  logic       clk_pri = 0, clk_sec = 0, clk_int = 0;
  logic       rst_n = 0;
  logic [1:0] sel = 2'b00;
  logic       pri_ok = 1, sec_ok = 1, int_ok = 1;
  logic       clk_sys, clk_aon, busy;

  sysclk_switch u0 (
    .clk_pri(clk_pri), .clk_sec(clk_sec), .clk_int(clk_int), .rst_n(rst_n),
    .sel(sel), .pri_ok(pri_ok), .sec_ok(sec_ok), .int_ok(int_ok),
    .clk_sys(clk_sys), .clk_aon(clk_aon), .busy(busy)
  );

  localparam int HALF [3] = '{2500, 30650, 6850};

  always #2500 clk_pri = ~clk_pri;
  initial begin #1234; forever #30650 clk_sec = ~clk_sec; end
  initial begin #777;  forever #6850  clk_int = ~clk_int; end

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  item_t q[$];
  int pushed = 0, done = 0;
  int cnt [3] = '{0, 0, 0};
  int off_snap [3], rise_snap [3];
  int rises = 0, handled = 0, nneg = 0, runt = 0;
  realtime last_pos = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic push(input int src, input bit chk_new);
    item_t it;
    it.src = src;
    it.chk_new = chk_new;
    q.push_back(it);
    pushed++;
  endtask

  always @(posedge clk_pri) cnt[0]++;
  always @(posedge clk_sec) cnt[1]++;
  always @(posedge clk_int) cnt[2]++;

  always @(negedge clk_sys) begin
    realtime w;
    nneg++;
    w = $realtime - last_pos;
    if (rst_n && !(w == HALF[0] || w == HALF[1] || w == HALF[2])) runt++;
    #1 off_snap = cnt;
  end
  always @(posedge clk_sys) last_pos = $realtime;

  always @(posedge busy) begin
    #1 rise_snap = cnt;
    rises++;
  end

  int cur_src = 0;

  // monitor: measures each completed switch and compares with the queue
  task automatic monitor();
    forever begin
      int c0 [3], off [3], crel [3];
      realtime t_fall, t_rel, t1, t2;
      item_t e;
      wait (rises > handled);
      handled++;
      c0 = rise_snap;
      wait (!busy);
      t_fall = $realtime;
      off = off_snap;
      @(posedge clk_sys);
      t_rel = $realtime;
      #1 crel = cnt;
      @(posedge clk_sys) t1 = $realtime;
      @(posedge clk_sys) t2 = $realtime;
      if (q.size() == 0) begin
        check(0, "R8", "unexpected switch", 0, 1);
      end else begin
        e = q.pop_front();
        // R4 two old edges after the registering edge
        check(off[cur_src] - c0[cur_src] == 2, "R4", "old edges",
              off[cur_src] - c0[cur_src], 2);
        // R5 three or four new edges in the pause
        if (e.chk_new)
          check((crel[e.src] - off[e.src] - 1) inside {3, 4}, "R5", "new edges",
                crel[e.src] - off[e.src] - 1, 3);
        // R7 busy falls half a new period before release
        check(longint'(t_rel - t_fall) == HALF[e.src], "R7", "busy fall lead",
              longint'(t_rel - t_fall), HALF[e.src]);
        // R1 output period matches the picked source
        check(longint'(t2 - t1) == 2 * HALF[e.src], "R1", "period",
              longint'(t2 - t1), 2 * HALF[e.src]);
        cur_src = e.src;
      end
      done++;
    end
  endtask

  initial begin
    #200_000_000;
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    realtime t1, t2;
    int r0, n0;
    #10_001;
    // R2 reset state
    check(clk_sys == 0, "R2", "clk_sys in reset", clk_sys, 0);
    check(busy == 1, "R2", "busy in reset", busy, 1);
    #10_000 rst_n = 1;
    wait (!busy);
    @(posedge clk_sys) t1 = $realtime;
    @(posedge clk_sys) t2 = $realtime;
    // R2 primary after reset
    check(longint'(t2 - t1) == 5000, "R2", "primary period", longint'(t2 - t1), 5000);
    #3;
    handled = rises;
    fork monitor(); join_none

    // R1 primary to secondary
    push(1, 1); #1111 sel = 2'b01;
    wait (done == pushed);
    // R9 always-on clock keeps primary
    @(posedge clk_aon) t1 = $realtime;
    @(posedge clk_aon) t2 = $realtime;
    check(longint'(t2 - t1) == 5000, "R9", "clk_aon period", longint'(t2 - t1), 5000);

    // R1 secondary to internal via code 10
    push(2, 1); #2222 sel = 2'b10;
    wait (done == pushed);

    // R10 code 11 names the same source
    r0 = rises;
    #3333 sel = 2'b11;
    #411_000;
    check(rises == r0, "R10", "no switch started", rises - r0, 0);
    check(busy == 0, "R10", "busy stays low", busy, 0);
    @(posedge clk_sys) t1 = $realtime;
    @(posedge clk_sys) t2 = $realtime;
    check(longint'(t2 - t1) == 13700, "R10", "internal period kept",
          longint'(t2 - t1), 13700);

    // R1 internal to primary
    push(0, 1); #1717 sel = 2'b00;
    wait (done == pushed);

    // R6 switch to an unready internal source
    int_ok = 0;
    push(2, 0); #2121 sel = 2'b10;
    wait (busy);
    #400_000;
    n0 = nneg;
    #200_000;
    check(nneg == n0, "R6", "no clock while unstable", nneg - n0, 0);
    check(busy == 1, "R6", "busy while unstable", busy, 1);
    check(clk_sys == 0, "R6", "output low while unstable", clk_sys, 0);
    #1313 int_ok = 1;
    wait (done == pushed);

    // R8 change during a switch is served afterwards
    push(1, 1); #1919 sel = 2'b01;
    wait (busy);
    #1000;
    push(0, 1); sel = 2'b00;
    wait (done == pushed);
    check(cur_src == 0, "R8", "final source", cur_src, 0);

    // R3 no runt pulses anywhere
    check(runt == 0, "R3", "runt high phases", runt, 0);
    finish_up();
  end

endmodule